// File: doc/BRIEF.md
# Extended Address Program Counter Unit

This unit holds the program counter of an 8051-style core whose code space reaches past 64K, and it sequences every control transfer that touches the counter: long and absolute jumps, calls, returns, interrupt returns and hardware interrupt entry. A two-bit mode field picks between a flat 16-bit mode and a 22-bit paged mode. In paged mode an 8-bit page register supplies the address bits above bit 15, so unmodified 16-bit code runs unchanged inside a page.

The decoder hands over one request at a time with its 16-bit operand, or with a vector for an interrupt. The unit moves return addresses through a byte-wide stack port, one byte per clock, and keeps its own stack pointer. The number of busy cycles per request follows the number of stack bytes. In paged mode that is one more than in 16-bit mode. Interrupt entry always lands in page zero. The page register is never saved or restored by the hardware, and only software writes through the SFR port change it.

Top module: `xpc_unit`

## Requirements
- R1: After reset the mode is 00, the PC is 0, the page register is 0, the stack pointer is 07h (idle stk_addr_o shows 07h) and busy_o is low.
- R2: The SFR port selects the page register with sfr_sel_i=0, the mode field (data bits 1:0) with 1 and the stack pointer with 2. Code 01 is the only wide (paged) mode, and codes 00, 10 and 11 act as 16-bit mode. A write that selects a 16-bit mode clears PC bits 21:16 at the same edge.
- R3: pc_inc_i adds one to the PC. In paged mode the carry passes into bit 16. In 16-bit mode the PC wraps from FFFFh to 0.
- R4: req_op_i codes are 0 long jump, 1 absolute call, 2 long call, 3 return, 4 interrupt return and 5 interrupt acknowledge, and codes 6 and 7 are ignored. A long jump loads {page[5:0], operand} in paged mode, or {0, operand} in 16-bit mode, at the accepting edge, and busy_o never rises.
- R5: A long call targets the same address as a long jump. An absolute call keeps PC bits 21:11 and takes bits 10:0 from the operand.
- R6: A push writes one byte per cycle to address SP+1 and increments SP, starting with PC bits 7:0, then bits 15:8, then bits 21:16 (zero-extended). Paged mode pushes three bytes and 16-bit mode pushes two.
- R7: Calls, returns and interrupt entry keep busy_o high for 2 cycles in 16-bit mode and 3 in paged mode, and raise done_o only in the last one. The PC takes its new value at the end of that cycle.
- R8: An interrupt acknowledge pushes the current PC and then loads {000000b, irq_vec_i}, whatever the page register holds.
- R9: A return or interrupt return reads stk_rdata_i at address SP and decrements SP, taking the upper byte first (paged mode only), then bits 15:8, then bits 7:0. The PC is loaded from these bytes, and bits 7:6 of the upper byte are dropped.
- R10: Interrupt entry and interrupt return leave the page register unchanged. Only an SFR write to the page register changes it.
- R11: While busy_o is high, new requests and pc_inc_i are ignored. pc_inc_i is also ignored in a cycle where a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Control-transfer request present |
| req_op_i | input | 3 | Request code |
| req_opnd_i | input | 16 | Jump or call operand |
| irq_vec_i | input | 16 | Interrupt vector address |
| pc_inc_i | input | 1 | Advance PC by one |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_sel_i | input | 2 | SFR select: page, mode, stack pointer |
| sfr_wdata_i | input | 8 | SFR write data |
| stk_we_o | output | 1 | Stack byte write |
| stk_re_o | output | 1 | Stack byte read |
| stk_addr_o | output | 8 | Stack byte address |
| stk_wdata_o | output | 8 | Stack write byte |
| stk_rdata_i | input | 8 | Stack read byte, same cycle |
| pc_o | output | 22 | Program counter |
| page_o | output | 8 | Address page register |
| mode_o | output | 2 | Address-mode field |
| busy_o | output | 1 | Stack sequence in progress |
| done_o | output | 1 | Last step of a sequence |

## Verification
The bench drives inputs and samples outputs at the falling edge. A jump, an SFR write or a PC increment therefore shows its result at the first falling edge after the input is taken. A call, return or interrupt entry shows busy_o from the first falling edge after acceptance. The bench counts busy cycles until busy_o drops and checks the PC and the stack bytes only after that. Each stack byte lands in the bench memory at the rising edge of its own step. Read bytes are served combinationally in the same cycle as the read. The ignore checks hold a competing request through the busy window and read the PC once the sequence has ended.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  typedef enum logic [2:0] {
    OP_LJMP  = 3'd0,
    OP_ACALL = 3'd1,
    OP_LCALL = 3'd2,
    OP_RET   = 3'd3,
    OP_RETI  = 3'd4,
    OP_INTA  = 3'd5
  } xpc_op_e;

  typedef enum logic [1:0] {
    SFR_PAGE = 2'd0,
    SFR_MODE = 2'd1,
    SFR_SP   = 2'd2,
    SFR_NONE = 2'd3
  } xpc_sfr_e;

  localparam logic [1:0] MODE_FLAT16 = 2'b00;
  localparam logic [1:0] MODE_PAGED  = 2'b01;

  // reserved codes fall back to 16-bit behaviour
  function automatic logic mode_is_wide(input logic [1:0] m);
    return m == MODE_PAGED;
  endfunction
endpackage

// File: rtl/xpc_mode_regs.sv
module xpc_mode_regs
  import xpc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_we_i,
  input  logic [1:0]        sfr_sel_i,
  input  logic [BYTE_W-1:0] sfr_wdata_i,
  output logic [1:0]        mode_o,
  output logic [BYTE_W-1:0] page_o,
  output logic              wide_o,
  output logic              narrow_wr_o
);
  logic [1:0]        mode_q;
  logic [BYTE_W-1:0] page_q;
  logic              page_wr, mode_wr;

  assign page_wr = sfr_we_i && (xpc_sfr_e'(sfr_sel_i) == SFR_PAGE);
  assign mode_wr = sfr_we_i && (xpc_sfr_e'(sfr_sel_i) == SFR_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FLAT16;
      page_q <= '0;
    end else begin
      if (mode_wr) mode_q <= sfr_wdata_i[1:0];
      if (page_wr) page_q <= sfr_wdata_i;
    end
  end

  assign mode_o      = mode_q;
  assign page_o      = page_q;
  assign wide_o      = mode_is_wide(mode_q);
  assign narrow_wr_o = mode_wr && !mode_is_wide(sfr_wdata_i[1:0]);

  assert_page_only_sfr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_wr |=> $stable(page_q));
endmodule

// File: rtl/xpc_target.sv
module xpc_target
  import xpc_pkg::*;
#(
  parameter int PC_W   = 22,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8,
  parameter int ABS_W  = 11
) (
  input  logic [2:0]        op_i,
  input  logic [HALF_W-1:0] opnd_i,
  input  logic [HALF_W-1:0] vec_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [BYTE_W-1:0] page_i,
  input  logic              wide_i,
  output logic [PC_W-1:0]   dest_o
);
  localparam int UP_W = PC_W - HALF_W;

  logic [UP_W-1:0] page_hi;
  assign page_hi = wide_i ? page_i[UP_W-1:0] : '0;

  always_comb begin
    unique case (xpc_op_e'(op_i))
      OP_ACALL: dest_o = {pc_i[PC_W-1:ABS_W], opnd_i[ABS_W-1:0]};
      OP_INTA:  dest_o = {{UP_W{1'b0}}, vec_i};
      default:  dest_o = {page_hi, opnd_i};
    endcase
  end
endmodule

// File: rtl/xpc_stack_seq.sv
module xpc_stack_seq #(
  parameter int             PC_W   = 22,
  parameter int             HALF_W = 16,
  parameter int             BYTE_W = 8,
  parameter int             SP_W   = 8,
  parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              push_i,
  input  logic              wide_i,
  input  logic [PC_W-1:0]   frame_i,
  input  logic              sp_we_i,
  input  logic [SP_W-1:0]   sp_wdata_i,
  input  logic [BYTE_W-1:0] stk_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PC_W-1:0]   pop_addr_o,
  output logic              stk_we_o,
  output logic              stk_re_o,
  output logic [SP_W-1:0]   stk_addr_o,
  output logic [BYTE_W-1:0] stk_wdata_o
);
  localparam int FRAME_B = (PC_W + BYTE_W - 1) / BYTE_W;
  localparam int HALF_B  = HALF_W / BYTE_W;
  localparam int FRAME_W = FRAME_B * BYTE_W;
  localparam int CNT_W   = $clog2(FRAME_B + 1);

  logic               active_q, push_q;
  logic [CNT_W-1:0]   nbytes_q, idx_q, pos;
  logic [FRAME_W-1:0] frame_q, acc_q, acc_full;
  logic [SP_W-1:0]    sp_q;
  logic               last;
  logic [BYTE_W-1:0]  push_byte [FRAME_B];

  for (genvar g = 0; g < FRAME_B; g++) begin : g_bytes
    assign push_byte[g] = frame_q[g*BYTE_W +: BYTE_W];
  end

  assign last = (idx_q == nbytes_q - CNT_W'(1));
  assign pos  = nbytes_q - CNT_W'(1) - idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      push_q   <= 1'b0;
      nbytes_q <= '0;
      idx_q    <= '0;
      frame_q  <= '0;
      acc_q    <= '0;
      sp_q     <= SP_RST;
    end else if (active_q) begin
      sp_q  <= push_q ? sp_q + SP_W'(1) : sp_q - SP_W'(1);
      idx_q <= idx_q + CNT_W'(1);
      if (!push_q) begin
        for (int g = 0; g < FRAME_B; g++)
          if (CNT_W'(g) == pos) acc_q[g*BYTE_W +: BYTE_W] <= stk_rdata_i;
      end
      if (last) active_q <= 1'b0;
    end else begin
      if (sp_we_i) sp_q <= sp_wdata_i;
      if (start_i) begin
        active_q <= 1'b1;
        push_q   <= push_i;
        nbytes_q <= wide_i ? CNT_W'(FRAME_B) : CNT_W'(HALF_B);
        idx_q    <= '0;
        frame_q  <= FRAME_W'(frame_i);
        acc_q    <= '0;
      end
    end
  end

  // last byte read is always bits 7:0
  assign acc_full   = {acc_q[FRAME_W-1:BYTE_W], stk_rdata_i};
  assign pop_addr_o = acc_full[PC_W-1:0];
  assign busy_o     = active_q;
  assign done_o     = active_q && last;
  assign stk_we_o   = active_q && push_q;
  assign stk_re_o   = active_q && !push_q;
  assign stk_addr_o = push_q ? sp_q + SP_W'(1) : sp_q;
  assign stk_wdata_o = push_byte[idx_q];

  assert_push_preinc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o |=> sp_q == $past(sp_q) + SP_W'(1));
  assert_pop_postdec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_re_o |=> sp_q == $past(sp_q) - SP_W'(1));
  assert_start_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_seq_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_idx_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> idx_q < nbytes_q);
endmodule

// File: rtl/xpc_unit.sv
module xpc_unit
  import xpc_pkg::*;
#(
  parameter int              PC_W   = 22,
  parameter int              HALF_W = 16,
  parameter int              BYTE_W = 8,
  parameter int              SP_W   = 8,
  parameter int              ABS_W  = 11,
  parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [HALF_W-1:0] req_opnd_i,
  input  logic [HALF_W-1:0] irq_vec_i,
  input  logic              pc_inc_i,
  input  logic              sfr_we_i,
  input  logic [1:0]        sfr_sel_i,
  input  logic [BYTE_W-1:0] sfr_wdata_i,
  output logic              stk_we_o,
  output logic              stk_re_o,
  output logic [SP_W-1:0]   stk_addr_o,
  output logic [BYTE_W-1:0] stk_wdata_o,
  input  logic [BYTE_W-1:0] stk_rdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [BYTE_W-1:0] page_o,
  output logic [1:0]        mode_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int UP_W = PC_W - HALF_W;

  xpc_op_e           op;
  logic              known, accept, is_jump, is_pop, start;
  logic              wide, narrow_wr, busy, done, sp_we;
  logic [BYTE_W-1:0] page;
  logic [PC_W-1:0]   pc_q, pc_n, dest, dest_q, pop_addr;
  logic              pop_q;
  xpc_op_e           op_q;

  assign op      = xpc_op_e'(req_op_i);
  assign known   = op inside {OP_LJMP, OP_ACALL, OP_LCALL, OP_RET, OP_RETI, OP_INTA};
  assign accept  = req_valid_i && known && !busy;
  assign is_jump = (op == OP_LJMP);
  assign is_pop  = (op == OP_RET) || (op == OP_RETI);
  assign start   = accept && !is_jump;
  assign sp_we   = sfr_we_i && (xpc_sfr_e'(sfr_sel_i) == SFR_SP);

  xpc_mode_regs #(.BYTE_W(BYTE_W)) u_mode (
    .clk_i, .rst_ni, .sfr_we_i, .sfr_sel_i, .sfr_wdata_i,
    .mode_o, .page_o(page), .wide_o(wide), .narrow_wr_o(narrow_wr)
  );

  xpc_target #(.PC_W(PC_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W), .ABS_W(ABS_W)) u_tgt (
    .op_i(req_op_i), .opnd_i(req_opnd_i), .vec_i(irq_vec_i),
    .pc_i(pc_q), .page_i(page), .wide_i(wide), .dest_o(dest)
  );

  xpc_stack_seq #(.PC_W(PC_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W), .SP_W(SP_W),
                  .SP_RST(SP_RST)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .push_i(!is_pop), .wide_i(wide),
    .frame_i(pc_q), .sp_we_i(sp_we), .sp_wdata_i(SP_W'(sfr_wdata_i)),
    .stk_rdata_i, .busy_o(busy), .done_o(done), .pop_addr_o(pop_addr),
    .stk_we_o, .stk_re_o, .stk_addr_o, .stk_wdata_o
  );

  always_comb begin
    pc_n = pc_q;
    if (accept && is_jump)                pc_n = dest;
    else if (done)                        pc_n = pop_q ? pop_addr : dest_q;
    else if (pc_inc_i && !busy && !accept)
      pc_n = wide ? pc_q + PC_W'(1)
                  : {{UP_W{1'b0}}, pc_q[HALF_W-1:0] + HALF_W'(1)};
    if (narrow_wr) pc_n[PC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      dest_q <= '0;
      pop_q  <= 1'b0;
      op_q   <= OP_LJMP;
    end else begin
      pc_q <= pc_n;
      if (start) begin
        dest_q <= dest;
        pop_q  <= is_pop;
        op_q   <= op;
      end
    end
  end

  assign pc_o   = pc_q;
  assign page_o = page;
  assign busy_o = busy;
  assign done_o = done;

  assert_vec_page0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && op_q == OP_INTA |=> pc_q[PC_W-1:HALF_W] == '0);
  assert_jump_no_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_jump |=> !busy_o);
  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done && !narrow_wr |=> $stable(pc_q));
  assert_flat_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_i && !busy && !req_valid_i && !sfr_we_i && !wide && pc_q[HALF_W-1:0] == '1
    |=> pc_q == '0);
endmodule

// File: tb/xpc_unit_tb_top.sv
module xpc_unit_tb_top;
  import xpc_pkg::*;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  page;
    logic [15:0] setup;
    logic [2:0]  op;
    logic [15:0] arg;
    logic [21:0] exp_pc;
    logic [1:0]  exp_n;
    logic [23:0] exp_mem; // bytes at 33h,32h,31h
  } vec_t;

  // stack preload: 30h=C5 2Fh=9A 2Eh=3C, sentinel EE at 31h..33h, SP=30h
  localparam vec_t VECS [11] = '{
    '{2'd0, 8'h12, 16'h1234, 3'd2, 16'hBEEF, 22'h00BEEF, 2'd2, 24'hEE1234},
    '{2'd1, 8'h12, 16'h1234, 3'd2, 16'hBEEF, 22'h12BEEF, 2'd3, 24'h121234},
    '{2'd1, 8'h2B, 16'h5000, 3'd1, 16'h07FF, 22'h2B57FF, 2'd3, 24'h2B5000},
    '{2'd0, 8'h2B, 16'h5000, 3'd1, 16'hFFFF, 22'h0057FF, 2'd2, 24'hEE5000},
    '{2'd1, 8'h33, 16'hABCD, 3'd5, 16'h000B, 22'h00000B, 2'd3, 24'h33ABCD},
    '{2'd0, 8'h33, 16'hABCD, 3'd5, 16'h0013, 22'h000013, 2'd2, 24'hEEABCD},
    '{2'd1, 8'h01, 16'h0100, 3'd3, 16'h0000, 22'h059A3C, 2'd3, 24'hEEEEEE},
    '{2'd0, 8'h01, 16'h0100, 3'd4, 16'h0000, 22'h00C59A, 2'd2, 24'hEEEEEE},
    '{2'd1, 8'h3F, 16'h0000, 3'd0, 16'h8001, 22'h3F8001, 2'd0, 24'hEEEEEE},
    '{2'd2, 8'h3F, 16'h1111, 3'd2, 16'h4444, 22'h004444, 2'd2, 24'hEE1111},
    '{2'd3, 8'h3F, 16'h1111, 3'd3, 16'h0000, 22'h00C59A, 2'd2, 24'hEEEEEE}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, pc_inc = 1'b0, sfr_we = 1'b0;
  logic [2:0]  req_op = '0;
  logic [15:0] req_opnd = '0, irq_vec = '0;
  logic [1:0]  sfr_sel = '0;
  logic [7:0]  sfr_wdata = '0;
  logic        stk_we, stk_re, busy, done;
  logic [7:0]  stk_addr, stk_wdata, stk_rdata, page;
  logic [21:0] pc;
  logic [1:0]  mode;
  logic        pl_we = 1'b0;
  logic [7:0]  pl_addr = '0, pl_data = '0;
  logic [7:0]  mem [256];
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    else if (pl_we) mem[pl_addr] <= pl_data;
  end
  assign stk_rdata = mem[stk_addr];

  xpc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_opnd_i(req_opnd), .irq_vec_i(irq_vec), .pc_inc_i(pc_inc),
    .sfr_we_i(sfr_we), .sfr_sel_i(sfr_sel), .sfr_wdata_i(sfr_wdata),
    .stk_we_o(stk_we), .stk_re_o(stk_re), .stk_addr_o(stk_addr),
    .stk_wdata_o(stk_wdata), .stk_rdata_i(stk_rdata), .pc_o(pc),
    .page_o(page), .mode_o(mode), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sfr(input logic [1:0] sel, input logic [7:0] d);
    sfr_we = 1'b1; sfr_sel = sel; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] arg,
                       output int nbusy, output int ndone);
    req_valid = 1'b1; req_op = op; req_opnd = arg; irq_vec = arg;
    @(negedge clk);
    req_valid = 1'b0;
    nbusy = 0; ndone = 0;
    while (busy && nbusy < 8) begin
      nbusy++;
      if (done) ndone++;
      @(negedge clk);
    end
  endtask

  function automatic string pc_tag(input logic [2:0] op);
    case (op)
      3'd0:       return "R4 jump pc";
      3'd1, 3'd2: return "R5 call pc";
      3'd5:       return "R8 vector pc";
      default:    return "R9 return pc";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int nb, nd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pc", 32'(pc), 32'h0);
    check("R1 page", 32'(page), 32'h0);
    check("R1 mode", 32'(mode), 32'h0);
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 sp", 32'(stk_addr), 32'h07);

    foreach (VECS[i]) begin
      sfr(2'd2, 8'h30);
      poke(8'h31, 8'hEE); poke(8'h32, 8'hEE); poke(8'h33, 8'hEE);
      poke(8'h2E, 8'h3C); poke(8'h2F, 8'h9A); poke(8'h30, 8'hC5);
      sfr(2'd1, {6'd0, VECS[i].mode});
      sfr(2'd0, VECS[i].page);
      issue(3'd0, VECS[i].setup, nb, nd);
      issue(VECS[i].op, VECS[i].arg, nb, nd);
      check(pc_tag(VECS[i].op), 32'(pc), 32'(VECS[i].exp_pc));
      check("R7 busy cycles", 32'(nb), 32'(VECS[i].exp_n));
      check("R7 done pulses", 32'(nd), (VECS[i].exp_n == 0) ? 32'd0 : 32'd1);
      check("R6 stack bytes", 32'({mem[8'h33], mem[8'h32], mem[8'h31]}), 32'(VECS[i].exp_mem));
      check("R10 page kept", 32'(page), 32'(VECS[i].page));
      check("R2 mode field", 32'(mode), 32'(VECS[i].mode));
    end

    // R3 carry into bit 16 in paged mode
    sfr(2'd1, 8'h01); sfr(2'd0, 8'h00);
    issue(3'd0, 16'hFFFF, nb, nd);
    pc_inc = 1'b1; @(negedge clk); pc_inc = 1'b0;
    check("R3 paged carry", 32'(pc), 32'h010000);
    // R3 wrap in 16-bit mode
    sfr(2'd1, 8'h00);
    issue(3'd0, 16'hFFFF, nb, nd);
    pc_inc = 1'b1; @(negedge clk); pc_inc = 1'b0;
    check("R3 flat wrap", 32'(pc), 32'h000000);

    // R2 narrowing write clears upper PC bits; R4 paged jump
    sfr(2'd1, 8'h01); sfr(2'd0, 8'h05);
    issue(3'd0, 16'h0001, nb, nd);
    check("R4 paged jump", 32'(pc), 32'h050001);
    sfr(2'd1, 8'h00);
    check("R2 narrow clears upper", 32'(pc), 32'h000001);

    // R4 unknown op code ignored
    issue(3'd7, 16'h9999, nb, nd);
    check("R4 op 7 ignored pc", 32'(pc), 32'h000001);
    check("R4 op 7 no busy", 32'(nb), 32'h0);

    // R11 requests and increments ignored while busy
    sfr(2'd2, 8'h30);
    req_valid = 1'b1; req_op = 3'd2; req_opnd = 16'h2222;
    @(negedge clk);
    req_op = 3'd0; req_opnd = 16'h7777; pc_inc = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; pc_inc = 1'b0;
    @(negedge clk);
    check("R11 busy ignore", 32'(pc), 32'h002222);
    check("R11 idle after", 32'(busy), 32'h0);

    // R8 R10 interrupt entry in page zero and return across a page change
    sfr(2'd1, 8'h01); sfr(2'd0, 8'h21); sfr(2'd2, 8'h30);
    issue(3'd0, 16'h4321, nb, nd);
    issue(3'd5, 16'h0003, nb, nd);
    check("R8 vector page zero", 32'(pc), 32'h000003);
    check("R10 page after entry", 32'(page), 32'h21);
    sfr(2'd0, 8'h05);
    issue(3'd4, 16'h0000, nb, nd);
    check("R9 reti restores", 32'(pc), 32'h214321);
    check("R10 page after reti", 32'(page), 32'h05);
    check("R7 reti cycles", 32'(nb), 32'd3);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule